// File: doc/BRIEF.md
# Three-Port Parallel Peripheral Interface

This block is a parallel I/O controller that connects a processor's 8-bit data bus to three 8-bit peripheral ports (A, B, C). The processor selects one of four registers with a two-bit address: the three ports or a control register. A register is read or written only while chip select is high together with the read or the write strobe. Pins are modelled as separate input, output and output-enable vectors, so the block sits behind whatever pad logic the chip provides.

Writes to the control register either set the operating configuration or set or clear a single port C bit. In the basic configuration each port is a plain input or output, and port C is split into two independently directed 4-bit halves. In the strobed configuration, ports A and B move data under a handshake. Some port C lines become strobe or acknowledge inputs from the device, buffer-full indications to it, and interrupt requests to the processor. The interrupt requests are gated by enable bits held in the port C output latch.

Top module: `ppi_top`

## Requirements
- R1: After reset the configuration word is 0x9B (every port an input, basic configuration). All output latches are zero, all output enables are low, and `dataOut` is 0.
- R2: A register is written only on a clock edge where `chipSel` and `wrStrobe` are both high. `dataOut` is 0 whenever `chipSel` and `rdStrobe` are not both high, and a write strobe without chip select changes no output.
- R3: `addr` selects port A at 0, port B at 1, port C at 2 and the control register at 3. Reading address 3 returns the last configuration word.
- R4: A control write with bit 7 = 1 is a configuration word. Bits 6:5 give the group A configuration (00 basic, anything else strobed). Bit 4 makes port A an input, bit 3 makes port C bits 7:4 inputs, bit 2 selects strobed operation for group B, bit 1 makes port B an input, and bit 0 makes port C bits 3:0 inputs. An output port has all its enables high; an input port has them low.
- R5: In the basic configuration, reading an input port returns its pins. Reading an output port returns its latch. A port C read returns, for each bit, the driven value if its enable is high and otherwise the pin.
- R6: Writing a configuration word clears the A, B and C output latches and all handshake state.
- R7: A control write with bit 7 = 0 sets port C latch bit `dataIn[3:1]` to `dataIn[0]` and leaves the other bits unchanged.
- R8: Strobed input on port A uses these lines: C4 is an active-low strobe input, C5 drives input-buffer-full (high = full) and C3 drives the A interrupt request. A falling C4 latches the A pins and sets buffer-full. A read of port A returns the latched byte and clears buffer-full and the request.
- R9: The A request appears on C3 only while its enable is set. The enable is latch bit C4 for input and C6 for output. The B request appears on C0 only while latch bit C2 is set. A pending request appears as soon as its enable is set.
- R10: Strobed output on port B uses these lines: C2 is an active-low acknowledge input, C1 drives output-buffer-full (low = full) and C0 drives the B interrupt request. A write to port B drives C1 low and clears the request. A falling C2 drives C1 high and raises the request.
- R11: In strobed A output, C7 drives the active-low buffer-full line and C6 is the acknowledge input. The handshake lines have fixed enables (outputs high, strobe/acknowledge inputs low). The other port C bits follow their half's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel | input | 1 | Chip select, active high |
| rdStrobe | input | 1 | Read strobe, active high |
| wrStrobe | input | 1 | Write strobe, active high |
| addr | input | 2 | Register select |
| dataIn | input | 8 | Write data from processor |
| dataOut | output | 8 | Read data to processor, 0 when not reading |
| paIn | input | 8 | Port A pin levels |
| paOut | output | 8 | Port A drive values |
| paOe | output | 8 | Port A output enables |
| pbIn | input | 8 | Port B pin levels |
| pbOut | output | 8 | Port B drive values |
| pbOe | output | 8 | Port B output enables |
| pcIn | input | 8 | Port C pin levels |
| pcOut | output | 8 | Port C drive values |
| pcOe | output | 8 | Port C output enables |

## Verification
Read data is combinational, so the bench samples `dataOut` 2 ns after it raises the read strobe, within the same cycle. Writes, read side effects and pin strobes act at the next rising edge. The bench applies every stimulus on a falling edge and checks the registered result on the following falling edge, one edge later. Strobe and acknowledge falls are detected against the previous sampled pin level, so the bench holds each line low for one full cycle before it checks the handshake outputs.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 2;
  localparam int HALF_W = PORT_W / 2;
  localparam int SEL_W  = $clog2(PORT_W);

  localparam logic [ADDR_W-1:0] SEL_A    = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_B    = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_C    = 2'd2;
  localparam logic [ADDR_W-1:0] SEL_CTRL = 2'd3;

  localparam logic [PORT_W-1:0] RESET_CFG = 8'h9B;

  // port C line roles in strobed operation
  localparam int PC_INTR_B = 0;
  localparam int PC_BUF_B  = 1;
  localparam int PC_STB_B  = 2;
  localparam int PC_INTR_A = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_IBF_A  = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OBF_A  = 7;

  typedef struct packed {
    logic wrA;
    logic wrB;
    logic wrC;
    logic wrCfg;
    logic wrBit;
    logic rdA;
    logic rdB;
    logic rdC;
    logic rdCfg;
  } busStrobes_t;

  typedef struct packed {
    logic strobedA;
    logic aIn;
    logic cHiIn;
    logic strobedB;
    logic bIn;
    logic cLoIn;
  } portCfg_t;

  typedef struct packed {
    logic bufFull;
    logic intr;
    logic latch;
  } hsStat_t;

  function automatic portCfg_t decodeCfg(input logic [PORT_W-1:0] w);
    portCfg_t c;
    c.strobedA = |w[6:5];
    c.aIn      = w[4];
    c.cHiIn    = w[3];
    c.strobedB = w[2];
    c.bIn      = w[1];
    c.cLoIn    = w[0];
    return c;
  endfunction
endpackage

// File: rtl/ppi_hs_unit.sv
module ppi_hs_unit
  import ppi_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    active,
  input  logic    isInput,
  input  logic    stbN,
  input  logic    inte,
  input  logic    cpuRd,
  input  logic    cpuWr,
  input  logic    clear,
  output hsStat_t stat
);
  logic prevQ;
  logic fullQ;
  logic pendQ;
  logic fallEdge;

  assign fallEdge = prevQ & ~stbN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= 1'b1;
      fullQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      prevQ <= stbN;
      if (clear || !active) begin
        fullQ <= 1'b0;
        pendQ <= 1'b0;
      end else if (isInput) begin
        if (fallEdge) begin
          fullQ <= 1'b1;
          pendQ <= 1'b1;
        end else if (cpuRd) begin
          fullQ <= 1'b0;
          pendQ <= 1'b0;
        end
      end else begin
        if (cpuWr) begin
          fullQ <= 1'b1;
          pendQ <= 1'b0;
        end else if (fallEdge) begin
          fullQ <= 1'b0;
          pendQ <= 1'b1;
        end
      end
    end
  end

  assign stat.bufFull = fullQ;
  assign stat.intr    = pendQ & inte;
  assign stat.latch   = active & isInput & fallEdge & ~clear;
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] dataIn,
  input  logic              stbPinA,
  input  logic              stbPinB,
  input  logic              inteA,
  input  logic              inteB,
  output busStrobes_t       strb,
  output logic [PORT_W-1:0] cfgWord,
  output portCfg_t          cfg,
  output hsStat_t           hsA,
  output hsStat_t           hsB
);
  localparam int N_HS = 2;

  logic wrHit;
  logic rdHit;
  logic [PORT_W-1:0] cfgQ;

  assign wrHit = chipSel & wrStrobe;
  assign rdHit = chipSel & rdStrobe;

  always_comb begin
    strb       = '0;
    strb.wrA   = wrHit && (addr == SEL_A);
    strb.wrB   = wrHit && (addr == SEL_B);
    strb.wrC   = wrHit && (addr == SEL_C);
    strb.wrCfg = wrHit && (addr == SEL_CTRL) && dataIn[PORT_W-1];
    strb.wrBit = wrHit && (addr == SEL_CTRL) && !dataIn[PORT_W-1];
    strb.rdA   = rdHit && (addr == SEL_A);
    strb.rdB   = rdHit && (addr == SEL_B);
    strb.rdC   = rdHit && (addr == SEL_C);
    strb.rdCfg = rdHit && (addr == SEL_CTRL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cfgQ <= RESET_CFG;
    else if (strb.wrCfg) cfgQ <= dataIn;
  end

  assign cfgWord = cfgQ;
  assign cfg     = decodeCfg(cfgQ);

  logic    hsActive [N_HS];
  logic    hsIsIn   [N_HS];
  logic    hsStb    [N_HS];
  logic    hsInte   [N_HS];
  logic    hsRd     [N_HS];
  logic    hsWr     [N_HS];
  hsStat_t hsStat   [N_HS];

  always_comb begin
    hsActive[0] = cfg.strobedA;
    hsIsIn[0]   = cfg.aIn;
    hsStb[0]    = stbPinA;
    hsInte[0]   = inteA;
    hsRd[0]     = strb.rdA;
    hsWr[0]     = strb.wrA;
    hsActive[1] = cfg.strobedB;
    hsIsIn[1]   = cfg.bIn;
    hsStb[1]    = stbPinB;
    hsInte[1]   = inteB;
    hsRd[1]     = strb.rdB;
    hsWr[1]     = strb.wrB;
  end

  for (genvar g = 0; g < N_HS; g++) begin : gHs
    ppi_hs_unit hs_i (
      .clk    (clk),
      .rstN   (rstN),
      .active (hsActive[g]),
      .isInput(hsIsIn[g]),
      .stbN   (hsStb[g]),
      .inte   (hsInte[g]),
      .cpuRd  (hsRd[g]),
      .cpuWr  (hsWr[g]),
      .clear  (strb.wrCfg),
      .stat   (hsStat[g])
    );
  end

  assign hsA = hsStat[0];
  assign hsB = hsStat[1];
endmodule

// File: rtl/ppi_datapath.sv
module ppi_datapath
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  portCfg_t          cfg,
  input  logic [PORT_W-1:0] cfgWord,
  input  hsStat_t           hsA,
  input  hsStat_t           hsB,
  input  logic [PORT_W-1:0] dataIn,
  output logic [PORT_W-1:0] dataOut,
  input  logic [PORT_W-1:0] paIn,
  output logic [PORT_W-1:0] paOut,
  output logic [PORT_W-1:0] paOe,
  input  logic [PORT_W-1:0] pbIn,
  output logic [PORT_W-1:0] pbOut,
  output logic [PORT_W-1:0] pbOe,
  input  logic [PORT_W-1:0] pcIn,
  output logic [PORT_W-1:0] pcOut,
  output logic [PORT_W-1:0] pcOe,
  output logic              stbPinA,
  output logic              stbPinB,
  output logic              inteA,
  output logic              inteB
);
  logic [PORT_W-1:0] aLatQ, bLatQ, cLatQ;
  logic [PORT_W-1:0] aCapQ, bCapQ;
  logic [SEL_W-1:0]  bitSel;

  assign bitSel = dataIn[SEL_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aLatQ <= '0;
      bLatQ <= '0;
      cLatQ <= '0;
    end else if (strb.wrCfg) begin
      aLatQ <= '0;
      bLatQ <= '0;
      cLatQ <= '0;
    end else begin
      if (strb.wrA)   aLatQ <= dataIn;
      if (strb.wrB)   bLatQ <= dataIn;
      if (strb.wrC)   cLatQ <= dataIn;
      if (strb.wrBit) cLatQ[bitSel] <= dataIn[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aCapQ <= '0;
      bCapQ <= '0;
    end else begin
      if (hsA.latch) aCapQ <= paIn;
      if (hsB.latch) bCapQ <= pbIn;
    end
  end

  // handshake line routing
  assign stbPinA = cfg.aIn ? pcIn[PC_STB_A] : pcIn[PC_ACK_A];
  assign stbPinB = pcIn[PC_STB_B];
  assign inteA   = cfg.aIn ? cLatQ[PC_STB_A] : cLatQ[PC_ACK_A];
  assign inteB   = cLatQ[PC_STB_B];

  assign paOut = aLatQ;
  assign pbOut = bLatQ;
  assign paOe  = {PORT_W{~cfg.aIn}};
  assign pbOe  = {PORT_W{~cfg.bIn}};

  always_comb begin
    pcOut = cLatQ;
    pcOe  = {{HALF_W{~cfg.cHiIn}}, {HALF_W{~cfg.cLoIn}}};
    if (cfg.strobedB) begin
      pcOe[PC_INTR_B]  = 1'b1;
      pcOut[PC_INTR_B] = hsB.intr;
      pcOe[PC_BUF_B]   = 1'b1;
      pcOut[PC_BUF_B]  = cfg.bIn ? hsB.bufFull : ~hsB.bufFull;
      pcOe[PC_STB_B]   = 1'b0;
    end
    if (cfg.strobedA) begin
      pcOe[PC_INTR_A]  = 1'b1;
      pcOut[PC_INTR_A] = hsA.intr;
      if (cfg.aIn) begin
        pcOe[PC_STB_A]  = 1'b0;
        pcOe[PC_IBF_A]  = 1'b1;
        pcOut[PC_IBF_A] = hsA.bufFull;
      end else begin
        pcOe[PC_ACK_A]  = 1'b0;
        pcOe[PC_OBF_A]  = 1'b1;
        pcOut[PC_OBF_A] = ~hsA.bufFull;
      end
    end
  end

  logic [PORT_W-1:0] rdA, rdB, rdC;

  always_comb begin
    if (!cfg.aIn)          rdA = aLatQ;
    else if (cfg.strobedA) rdA = aCapQ;
    else                   rdA = paIn;
    if (!cfg.bIn)          rdB = bLatQ;
    else if (cfg.strobedB) rdB = bCapQ;
    else                   rdB = pbIn;
    for (int i = 0; i < PORT_W; i++) rdC[i] = pcOe[i] ? pcOut[i] : pcIn[i];
  end

  always_comb begin
    dataOut = '0;
    if (strb.rdA)   dataOut = rdA;
    if (strb.rdB)   dataOut = rdB;
    if (strb.rdC)   dataOut = rdC;
    if (strb.rdCfg) dataOut = cfgWord;
  end
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] dataIn,
  output logic [PORT_W-1:0] dataOut,
  input  logic [PORT_W-1:0] paIn,
  output logic [PORT_W-1:0] paOut,
  output logic [PORT_W-1:0] paOe,
  input  logic [PORT_W-1:0] pbIn,
  output logic [PORT_W-1:0] pbOut,
  output logic [PORT_W-1:0] pbOe,
  input  logic [PORT_W-1:0] pcIn,
  output logic [PORT_W-1:0] pcOut,
  output logic [PORT_W-1:0] pcOe
);
  busStrobes_t       strb;
  portCfg_t          cfg;
  logic [PORT_W-1:0] cfgWord;
  hsStat_t           hsA, hsB;
  logic              stbPinA, stbPinB, inteA, inteB;

  ppi_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .chipSel (chipSel),
    .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe),
    .addr    (addr),
    .dataIn  (dataIn),
    .stbPinA (stbPinA),
    .stbPinB (stbPinB),
    .inteA   (inteA),
    .inteB   (inteB),
    .strb    (strb),
    .cfgWord (cfgWord),
    .cfg     (cfg),
    .hsA     (hsA),
    .hsB     (hsB)
  );

  ppi_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cfg    (cfg),
    .cfgWord(cfgWord),
    .hsA    (hsA),
    .hsB    (hsB),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .paIn   (paIn),
    .paOut  (paOut),
    .paOe   (paOe),
    .pbIn   (pbIn),
    .pbOut  (pbOut),
    .pbOe   (pbOe),
    .pcIn   (pcIn),
    .pcOut  (pcOut),
    .pcOe   (pcOe),
    .stbPinA(stbPinA),
    .stbPinB(stbPinB),
    .inteA  (inteA),
    .inteB  (inteB)
  );
endmodule

// File: rtl/ppi_checker.sv
module ppi_checker (
  input logic       clk,
  input logic       rstN,
  input logic       chipSel,
  input logic       rdStrobe,
  input logic       wrStrobe,
  input logic [1:0] addr,
  input logic [7:0] dataIn,
  input logic [7:0] dataOut,
  input logic [7:0] paOut,
  input logic [7:0] pbOut,
  input logic [7:0] pcIn,
  input logic [7:0] pcOut,
  input logic [7:0] cfgQ
);
  // R6
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && wrStrobe && addr == 2'd3 && dataIn[7]) |=> (paOut == 8'h00 && pbOut == 8'h00));

  // R2
  no_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> ($stable(paOut) && $stable(pbOut) && $stable(cfgQ)));

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(chipSel && rdStrobe) |-> dataOut == 8'h00);

  // R7
  bit_sr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && wrStrobe && addr == 2'd3 && !dataIn[7] && cfgQ[6:5] == 2'b00 && !cfgQ[2])
    |=> pcOut[$past(dataIn[3:1])] == $past(dataIn[0]));

  // R10
  obf_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && wrStrobe && addr == 2'd1 && cfgQ[2] && !cfgQ[1])
    |=> (pcOut[1] == 1'b0 && pcOut[0] == 1'b0));

  // R8
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pcIn[4]) && cfgQ[6:5] != 2'b00 && cfgQ[4] && !(chipSel && wrStrobe && addr == 2'd3))
    |=> pcOut[5] == 1'b1);
endmodule

bind ppi_top ppi_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .chipSel (chipSel),
  .rdStrobe(rdStrobe),
  .wrStrobe(wrStrobe),
  .addr    (addr),
  .dataIn  (dataIn),
  .dataOut (dataOut),
  .paOut   (paOut),
  .pbOut   (pbOut),
  .pcIn    (pcIn),
  .pcOut   (pcOut),
  .cfgQ    (cfgWord)
);

// File: tb/ppi_top_tb.sv
module ppi_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSel = 1'b0, rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic [7:0] paIn = '0, pbIn = '0, pcIn = 8'hFF;
  logic [7:0] paOut, paOe, pbOut, pbOe, pcOut, pcOe;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ppi_top dut_i (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .paIn(paIn), .paOut(paOut), .paOe(paOe), .pbIn(pbIn), .pbOut(pbOut),
    .pbOe(pbOe), .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    chipSel = 1'b1; wrStrobe = 1'b1; addr = a; dataIn = d;
    @(negedge clk);
    chipSel = 1'b0; wrStrobe = 1'b0; dataIn = '0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    chipSel = 1'b1; rdStrobe = 1'b1; addr = a;
    #2 d = dataOut;
    @(negedge clk);
    chipSel = 1'b0; rdStrobe = 1'b0;
  endtask

  task automatic pulsePc(input int bitIdx);
    @(negedge clk);
    pcIn[bitIdx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic releasePc(input int bitIdx);
    pcIn[bitIdx] = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset;
    chk("R1 dataOut", dataOut, 8'h00);
    chk("R1 paOe", paOe, 8'h00);
    chk("R1 pcOe", pcOe, 8'h00);
    chk("R1 pbOut", pbOut, 8'h00);
  endtask

  task automatic testBasicOut;
    logic [7:0] v;
    busWrite(2'd3, 8'h80);
    chk("R4 paOe all out", paOe, 8'hFF);
    chk("R4 pcOe all out", pcOe, 8'hFF);
    busWrite(2'd0, 8'h5A);
    busWrite(2'd1, 8'hC3);
    busWrite(2'd2, 8'h96);
    chk("R3 paOut", paOut, 8'h5A);
    chk("R3 pbOut", pbOut, 8'hC3);
    chk("R3 pcOut", pcOut, 8'h96);
    busRead(2'd0, v);
    chk("R5 output readback A", v, 8'h5A);
    busRead(2'd2, v);
    chk("R5 port C readback", v, 8'h96);
    busRead(2'd3, v);
    chk("R3 config readback", v, 8'h80);
  endtask

  task automatic testStrobeGating;
    logic [7:0] v;
    @(negedge clk);
    wrStrobe = 1'b1; addr = 2'd0; dataIn = 8'hFF;
    @(negedge clk);
    wrStrobe = 1'b0;
    chk("R2 write without chipSel ignored", paOut, 8'h5A);
    @(negedge clk);
    rdStrobe = 1'b1; addr = 2'd0;
    #2 v = dataOut;
    @(negedge clk);
    rdStrobe = 1'b0;
    chk("R2 read without chipSel gives zero", v, 8'h00);
  endtask

  task automatic testCfgClear;
    busWrite(2'd3, 8'h80);
    chk("R6 A latch cleared", paOut, 8'h00);
    chk("R6 B latch cleared", pbOut, 8'h00);
    chk("R6 C latch cleared", pcOut, 8'h00);
  endtask

  task automatic testBasicIn;
    logic [7:0] v;
    busWrite(2'd3, 8'h9B);
    paIn = 8'h3C; pbIn = 8'hE1; pcIn = 8'hA5;
    chk("R4 inputs disable drive", pbOe, 8'h00);
    busRead(2'd0, v);
    chk("R5 A pins", v, 8'h3C);
    busRead(2'd1, v);
    chk("R5 B pins", v, 8'hE1);
    busWrite(2'd3, 8'h88);
    chk("R4 split C halves", pcOe, 8'h0F);
    busWrite(2'd2, 8'h0C);
    busRead(2'd2, v);
    chk("R5 C mixed read", v, 8'hAC);
    pcIn = 8'hFF;
  endtask

  task automatic testBitSetReset;
    busWrite(2'd3, 8'h80);
    busWrite(2'd3, 8'h0F);
    chk("R7 set bit 7", pcOut, 8'h80);
    busWrite(2'd3, 8'h05);
    chk("R7 set bit 2", pcOut, 8'h84);
    busWrite(2'd3, 8'h0E);
    chk("R7 clear bit 7", pcOut, 8'h04);
  endtask

  task automatic testStrobedInA;
    logic [7:0] v;
    busWrite(2'd3, 8'hB0);
    chk("R8 C enables strobed A in", pcOe, 8'hEF);
    busWrite(2'd3, 8'h09);
    paIn = 8'h77;
    pulsePc(4);
    chk("R8 buffer full set", pcOut[5], 1'b1);
    chk("R9 A request with enable", pcOut[3], 1'b1);
    paIn = 8'h11;
    releasePc(4);
    busRead(2'd0, v);
    chk("R8 latched byte returned", v, 8'h77);
    chk("R8 read clears buffer full", pcOut[5], 1'b0);
    chk("R8 read clears request", pcOut[3], 1'b0);
    busWrite(2'd3, 8'h08);
    pulsePc(4);
    releasePc(4);
    chk("R9 buffer full without enable", pcOut[5], 1'b1);
    chk("R9 request masked", pcOut[3], 1'b0);
    busWrite(2'd3, 8'h09);
    chk("R9 pending request shown on enable", pcOut[3], 1'b1);
  endtask

  task automatic testStrobedOutB;
    logic [7:0] v;
    busWrite(2'd3, 8'h84);
    chk("R10 C enables strobed B out", pcOe, 8'hFB);
    chk("R10 buffer empty after config", pcOut[1], 1'b1);
    busWrite(2'd3, 8'h05);
    busWrite(2'd1, 8'hA5);
    chk("R10 B data driven", pbOut, 8'hA5);
    chk("R10 write drives full low", pcOut[1], 1'b0);
    chk("R10 no request while full", pcOut[0], 1'b0);
    pulsePc(2);
    chk("R10 ack empties buffer", pcOut[1], 1'b1);
    chk("R10 ack raises request", pcOut[0], 1'b1);
    releasePc(2);
    busWrite(2'd1, 8'h5A);
    chk("R10 write clears request", pcOut[0], 1'b0);
    busRead(2'd3, v);
    chk("R3 config readback strobed", v, 8'h84);
  endtask

  task automatic testStrobedOutA;
    busWrite(2'd3, 8'hA0);
    chk("R11 C enables strobed A out", pcOe, 8'hBF);
    chk("R11 A buffer empty", pcOut[7], 1'b1);
    busWrite(2'd3, 8'h0D);
    busWrite(2'd0, 8'h3E);
    chk("R11 write drives C7 low", pcOut[7], 1'b0);
    pulsePc(6);
    chk("R11 ack on C6 empties", pcOut[7], 1'b1);
    chk("R9 A output request", pcOut[3], 1'b1);
    releasePc(6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicOut();
    testStrobeGating();
    testCfgClear();
    testBasicIn();
    testBitSetReset();
    testStrobedInA();
    testStrobedOutB();
    testStrobedOutA();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule